// File: doc/BRIEF.md
# DRAM address field decomposer

This block turns a 36-bit normalized memory-controller input address into the row, column and internal-bank fields of one chip-select, and packs them with the rank number into a single DIMM offset word. Which input-address bit feeds each field bit is not fixed in logic. Software loads bit-position tables through a small write port, and the tables are kept separately for each bank address mode. Each request names the mode that applies to its chip-select.

Two address transforms are optional and controlled by global enables. The first is chip-select interleave, which exchanges pairs of input-address positions before the row bits are sampled. The second is bank swizzle, which XORs each bank bit with two further address bits. Column extraction has a fixed reserved column position (the auto-precharge bit) that the column table steps over. In modes flagged as ambiguous, one column bit is dropped.

Requests carry no handshake. Each one produces a registered offset word exactly one cycle later.

Top module: `dram_addr_split`

## Requirements
- R1: When `req_valid` is high in a cycle, `out_valid` is high in the next cycle. When `req_valid` is low, `out_valid` is low in the next cycle. There is no back-pressure.
- R2: The offset word is packed, from LSB upward, as column [13:0], bank [16:14], row [32:17], rank [36:33], version [40:37] and valid flag [41]. For every result the version field equals 1, the valid flag is 1, and the rank field is the `req_rank` of the request.
- R3: Row bit k (k < nrows) is the input-address bit whose position is held in row-table entry k of the requested mode. Row bits at or above nrows are zero. nrows values above 16 act as 16.
- R4: While interleave is enabled, a row-table position that equals either member of a swap pair is replaced by the other member of that pair. Pairs are tested from index 0 upward and the first match wins.
- R5: Column bit k (k < active column count) reads column-table slot k when k < 10 and slot k+1 when k >= 10, so slot 10 is never used. Unused column bits are zero. ncols values above 14 act as 14.
- R6: When a mode's ambiguous flag is set, the active column count is ncols minus one, or zero if ncols is zero.
- R7: Bank bit k is the address bit at bank-table position k. While swizzle is enabled, it is additionally XORed with the two address bits named by swizzle pair k.
- R8: A write (`cfg_we`) updates one table entry selected by `cfg_tbl`:
  - 0 = row table: per mode, entries 0..15, data[5:0].
  - 1 = column table: per mode, slots 0..14.
  - 2 = geometry: per mode, data[4:0] nrows, data[8:5] ncols, data[9] ambiguous.
  - 3 = bank table: global, entries 0..2.
  - 4 = swizzle pair: global, entries 0..2, data[5:0] first and data[11:6] second.
  - 5 = swap pair: global, entries 0..1, same layout as the swizzle pair.
  - 6 = control: data[0] swizzle enable, data[1] interleave enable.
  
  A write with an index beyond the table changes nothing. A position of 36 or more reads as zero.
- R9: Reset clears `out_valid`, the offset word and every table and enable to zero.
- R10: In a cycle after one without a request, the offset word holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 3 | Table selector |
| cfg_mode | input | 2 | Bank address mode for per-mode tables |
| cfg_idx | input | 5 | Entry index within the table |
| cfg_data | input | 12 | Write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 36 | Normalized input address |
| req_mode | input | 2 | Bank address mode of the chip-select |
| req_rank | input | 4 | Rank number carried into the offset |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_word | output | 42 | Packed offset word |

## Verification
The assertions check the handshake behaviour on every cycle: the one-cycle valid latency, the return to idle, the holding of the word between requests, the constant valid and version fields, and the rank carried into each result.

The field contents depend on the programmed tables, so only the bench's scenarios can show them. It compares every result against a model of the tables. It also drives directed cases for:
- the skipped column slot;
- the dropped ambiguous column bit;
- swap-pair substitution and its priority;
- swizzle on and off;
- ignored out-of-range writes and positions of 36 or more.

// File: rtl/das_pkg.sv
package das_pkg;
    localparam int ADDR_W = 36;
    localparam int POS_W  = 6;
    localparam int SPAN   = 2 ** POS_W;
    localparam int CFG_W  = 2 * POS_W;

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [2:0] {
        TBL_ROW  = 3'd0,
        TBL_COL  = 3'd1,
        TBL_GEOM = 3'd2,
        TBL_BANK = 3'd3,
        TBL_SWZ  = 3'd4,
        TBL_SWAP = 3'd5,
        TBL_CTRL = 3'd6,
        TBL_NONE = 3'd7
    } tbl_e;

    typedef struct packed {
        logic       ambig;
        logic [3:0] ncols;
        logic [4:0] nrows;
    } geom_t;

    typedef struct packed {
        pos_t second;
        pos_t first;
    } pair_t;

    // Positions beyond the input address read as zero.
    function automatic logic pick(input logic [ADDR_W-1:0] a, input pos_t p);
        logic [SPAN-1:0] w;
        w = SPAN'(a);
        return w[p];
    endfunction
endpackage

// File: rtl/das_map_regs.sv
module das_map_regs
    import das_pkg::*;
#(
    parameter int NMODES    = 4,
    parameter int ROW_MAX   = 16,
    parameter int COL_SLOTS = 15,
    parameter int BANK_BITS = 3,
    parameter int NSWAP     = 2,
    parameter int MODE_W    = 2,
    parameter int IDX_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_tbl,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CFG_W-1:0]  cfg_data,
    output pos_t              row_map  [NMODES][ROW_MAX],
    output pos_t              col_map  [NMODES][COL_SLOTS],
    output geom_t             geom     [NMODES],
    output pos_t              bank_map [BANK_BITS],
    output pair_t             swz      [BANK_BITS],
    output pair_t             swap     [NSWAP],
    output logic              swz_en,
    output logic              csi_en
);
    tbl_e tsel;
    assign tsel = tbl_e'(cfg_tbl);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int m = 0; m < NMODES; m++) begin
                geom[m] <= '0;
                for (int k = 0; k < ROW_MAX; k++)   row_map[m][k] <= '0;
                for (int k = 0; k < COL_SLOTS; k++) col_map[m][k] <= '0;
            end
            for (int k = 0; k < BANK_BITS; k++) begin
                bank_map[k] <= '0;
                swz[k]      <= '0;
            end
            for (int k = 0; k < NSWAP; k++) swap[k] <= '0;
            swz_en <= 1'b0;
            csi_en <= 1'b0;
        end else if (cfg_we) begin
            for (int m = 0; m < NMODES; m++) begin
                if (cfg_mode == MODE_W'(m)) begin
                    if (tsel == TBL_GEOM) geom[m] <= geom_t'(cfg_data[9:0]);
                    for (int k = 0; k < ROW_MAX; k++)
                        if (tsel == TBL_ROW && cfg_idx == IDX_W'(k))
                            row_map[m][k] <= cfg_data[POS_W-1:0];
                    for (int k = 0; k < COL_SLOTS; k++)
                        if (tsel == TBL_COL && cfg_idx == IDX_W'(k))
                            col_map[m][k] <= cfg_data[POS_W-1:0];
                end
            end
            for (int k = 0; k < BANK_BITS; k++) begin
                if (tsel == TBL_BANK && cfg_idx == IDX_W'(k))
                    bank_map[k] <= cfg_data[POS_W-1:0];
                if (tsel == TBL_SWZ && cfg_idx == IDX_W'(k))
                    swz[k] <= pair_t'(cfg_data);
            end
            for (int k = 0; k < NSWAP; k++)
                if (tsel == TBL_SWAP && cfg_idx == IDX_W'(k))
                    swap[k] <= pair_t'(cfg_data);
            if (tsel == TBL_CTRL) begin
                swz_en <= cfg_data[0];
                csi_en <= cfg_data[1];
            end
        end
    end
endmodule

// File: rtl/das_field_extract.sv
module das_field_extract
    import das_pkg::*;
#(
    parameter int ROW_MAX   = 16,
    parameter int COL_MAX   = 14,
    parameter int COL_SLOTS = 15,
    parameter int BANK_BITS = 3,
    parameter int NSWAP     = 2,
    parameter int COL_SKIP  = 10
) (
    input  logic [ADDR_W-1:0]    addr,
    input  pos_t                 row_map  [ROW_MAX],
    input  pos_t                 col_map  [COL_SLOTS],
    input  geom_t                geom,
    input  pos_t                 bank_map [BANK_BITS],
    input  pair_t                swz      [BANK_BITS],
    input  pair_t                swap     [NSWAP],
    input  logic                 swz_en,
    input  logic                 csi_en,
    output logic [ROW_MAX-1:0]   row,
    output logic [COL_MAX-1:0]   col,
    output logic [BANK_BITS-1:0] bank
);
    int n_row;
    int n_col;

    always_comb begin
        n_row = (int'(geom.nrows) > ROW_MAX) ? ROW_MAX : int'(geom.nrows);
        n_col = (int'(geom.ncols) > COL_MAX) ? COL_MAX : int'(geom.ncols);
        if (geom.ambig && n_col > 0) n_col = n_col - 1;
    end

    for (genvar k = 0; k < ROW_MAX; k++) begin : g_row
        pos_t src;
        always_comb begin
            src = row_map[k];
            // Walk downward so the lowest matching pair is applied last.
            if (csi_en) begin
                for (int i = NSWAP - 1; i >= 0; i--) begin
                    if (row_map[k] == swap[i].first)       src = swap[i].second;
                    else if (row_map[k] == swap[i].second) src = swap[i].first;
                end
            end
        end
        assign row[k] = (k < n_row) && pick(addr, src);
    end

    for (genvar k = 0; k < COL_MAX; k++) begin : g_col
        localparam int SLOT = (k >= COL_SKIP) ? k + 1 : k;
        assign col[k] = (k < n_col) && pick(addr, col_map[SLOT]);
    end

    for (genvar k = 0; k < BANK_BITS; k++) begin : g_bank
        assign bank[k] = pick(addr, bank_map[k]) ^
                         (swz_en & (pick(addr, swz[k].first) ^ pick(addr, swz[k].second)));
    end
endmodule

// File: rtl/dram_addr_split.sv
module dram_addr_split
    import das_pkg::*;
#(
    parameter int NMODES      = 4,
    parameter int ROW_MAX     = 16,
    parameter int COL_MAX     = 14,
    parameter int BANK_BITS   = 3,
    parameter int NSWAP       = 2,
    parameter int COL_SKIP    = 10,
    parameter int RANK_W      = 4,
    parameter int VER_W       = 4,
    parameter int OFF_VERSION = 1,
    localparam int MODE_W     = (NMODES > 1) ? $clog2(NMODES) : 1,
    localparam int COL_SLOTS  = COL_MAX + 1,
    localparam int IDX_LIM    = (ROW_MAX > COL_SLOTS) ? ROW_MAX : COL_SLOTS,
    localparam int IDX_W      = $clog2(IDX_LIM + 1),
    localparam int WORD_W     = 1 + VER_W + RANK_W + ROW_MAX + BANK_BITS + COL_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_tbl,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [RANK_W-1:0] req_rank,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);
    pos_t  row_map  [NMODES][ROW_MAX];
    pos_t  col_map  [NMODES][COL_SLOTS];
    geom_t geom     [NMODES];
    pos_t  bank_map [BANK_BITS];
    pair_t swz      [BANK_BITS];
    pair_t swap     [NSWAP];
    logic  swz_en;
    logic  csi_en;

    das_map_regs #(
        .NMODES(NMODES), .ROW_MAX(ROW_MAX), .COL_SLOTS(COL_SLOTS),
        .BANK_BITS(BANK_BITS), .NSWAP(NSWAP), .MODE_W(MODE_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
        .cfg_mode(cfg_mode), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .row_map(row_map), .col_map(col_map), .geom(geom),
        .bank_map(bank_map), .swz(swz), .swap(swap),
        .swz_en(swz_en), .csi_en(csi_en)
    );

    // Select the tables of the requested mode.
    pos_t  sel_row  [ROW_MAX];
    pos_t  sel_col  [COL_SLOTS];
    geom_t sel_geom;

    always_comb begin
        for (int k = 0; k < ROW_MAX; k++)   sel_row[k] = row_map[req_mode][k];
        for (int k = 0; k < COL_SLOTS; k++) sel_col[k] = col_map[req_mode][k];
        sel_geom = geom[req_mode];
    end

    logic [ROW_MAX-1:0]   f_row;
    logic [COL_MAX-1:0]   f_col;
    logic [BANK_BITS-1:0] f_bank;

    das_field_extract #(
        .ROW_MAX(ROW_MAX), .COL_MAX(COL_MAX), .COL_SLOTS(COL_SLOTS),
        .BANK_BITS(BANK_BITS), .NSWAP(NSWAP), .COL_SKIP(COL_SKIP)
    ) u_extract (
        .addr(req_addr), .row_map(sel_row), .col_map(sel_col), .geom(sel_geom),
        .bank_map(bank_map), .swz(swz), .swap(swap),
        .swz_en(swz_en), .csi_en(csi_en),
        .row(f_row), .col(f_col), .bank(f_bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid)
                out_word <= {1'b1, VER_W'(OFF_VERSION), req_rank, f_row, f_bank, f_col};
        end
    end
endmodule

// File: rtl/das_checker.sv
module das_checker #(
    parameter int RANK_W      = 4,
    parameter int VER_W       = 4,
    parameter int OFF_VERSION = 1,
    parameter int WORD_W      = 42
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [RANK_W-1:0] req_rank,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word
);
    localparam int RANK_LO = WORD_W - 1 - VER_W - RANK_W;
    localparam int VER_LO  = WORD_W - 1 - VER_W;

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);  // R1

    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);  // R1

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(out_word));  // R10

    AST_FLAG_VERSION: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word[WORD_W-1] &&
                       out_word[VER_LO +: VER_W] == VER_W'(OFF_VERSION)));  // R2

    AST_RANK_CARRIED: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_word[RANK_LO +: RANK_W] == $past(req_rank));  // R2
endmodule

bind dram_addr_split das_checker #(
    .RANK_W(RANK_W), .VER_W(VER_W), .OFF_VERSION(OFF_VERSION), .WORD_W(WORD_W)
) u_das_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_rank(req_rank),
    .out_valid(out_valid), .out_word(out_word)
);

// File: tb/dram_addr_split_test.sv
`timescale 1ns/1ps
module dram_addr_split_test;
    localparam int ROWS = 16, COLS = 14, SLOTS = 15, BANKS = 3, NSW = 2, NM = 4;
    localparam int WW = 42;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_tbl = '0;
    logic [1:0]  cfg_mode = '0;
    logic [4:0]  cfg_idx = '0;
    logic [11:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic [1:0]  req_mode = '0;
    logic [3:0]  req_rank = '0;
    logic        out_valid;
    logic [WW-1:0] out_word;

    always #4 clk = ~clk;

    dram_addr_split uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
        .cfg_mode(cfg_mode), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_mode(req_mode),
        .req_rank(req_rank), .out_valid(out_valid), .out_word(out_word)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    // Model of the programmed tables.
    int m_row [NM][ROWS];
    int m_col [NM][SLOTS];
    int m_nr [NM], m_nc [NM];
    bit m_amb [NM];
    int m_bank [BANKS];
    int m_sz [BANKS][2];
    int m_sw [NSW][2];
    bit m_szen, m_csen;

    function automatic bit bit_at(logic [35:0] a, int p);
        return (p < 36) ? a[p] : 1'b0;
    endfunction

    function automatic logic [WW-1:0] model(logic [35:0] a, int md, logic [3:0] rk);
        logic [15:0] r = '0;
        logic [13:0] c = '0;
        logic [2:0]  b = '0;
        int nr = (m_nr[md] > ROWS) ? ROWS : m_nr[md];
        int nc = (m_nc[md] > COLS) ? COLS : m_nc[md];
        if (m_amb[md] && nc > 0) nc--;
        for (int k = 0; k < nr; k++) begin
            int p = m_row[md][k];
            bit hit = 0;
            if (m_csen)
                for (int i = 0; i < NSW; i++)
                    if (!hit) begin
                        if (p == m_sw[i][0])      begin p = m_sw[i][1]; hit = 1; end
                        else if (p == m_sw[i][1]) begin p = m_sw[i][0]; hit = 1; end
                    end
            r[k] = bit_at(a, p);
        end
        for (int k = 0; k < nc; k++)
            c[k] = bit_at(a, m_col[md][(k < 10) ? k : k + 1]);
        for (int k = 0; k < BANKS; k++)
            b[k] = bit_at(a, m_bank[k]) ^
                   (m_szen & (bit_at(a, m_sz[k][0]) ^ bit_at(a, m_sz[k][1])));
        return {1'b1, 4'd1, rk, r, b, c};
    endfunction

    task automatic check(string tag, logic [WW:0] act, logic [WW:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int tbl, int md, int idx, int data);
        cfg_we = 1'b1; cfg_tbl = 3'(tbl); cfg_mode = 2'(md);
        cfg_idx = 5'(idx); cfg_data = 12'(data);
        case (tbl)
            0: if (idx < ROWS)  m_row[md][idx] = data & 63;
            1: if (idx < SLOTS) m_col[md][idx] = data & 63;
            2: begin m_nr[md] = data & 31; m_nc[md] = (data >> 5) & 15; m_amb[md] = data[9]; end
            3: if (idx < BANKS) m_bank[idx] = data & 63;
            4: if (idx < BANKS) begin m_sz[idx][0] = data & 63; m_sz[idx][1] = (data >> 6) & 63; end
            5: if (idx < NSW)   begin m_sw[idx][0] = data & 63; m_sw[idx][1] = (data >> 6) & 63; end
            6: begin m_szen = data[0]; m_csen = data[1]; end
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic req(string tag, logic [35:0] a, int md, logic [3:0] rk);
        logic [WW-1:0] exp = model(a, md, rk);
        req_valid = 1'b1; req_addr = a; req_mode = 2'(md); req_rank = rk;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {out_valid, out_word}, {1'b1, exp});
    endtask

    task automatic idle(string tag);
        logic [WW-1:0] prev = out_word;
        req_addr = 36'hFFFFFFFFF;
        @(negedge clk);
        check(tag, {out_valid, out_word}, {1'b0, prev});
    endtask

    task automatic rand_cfg();
        for (int m = 0; m < NM; m++) begin
            wr(2, m, 0, int'($urandom_range(0, 1023)));
            for (int k = 0; k < ROWS; k++)  wr(0, m, k, int'($urandom_range(0, 39)));
            for (int k = 0; k < SLOTS; k++) wr(1, m, k, int'($urandom_range(0, 39)));
        end
        for (int k = 0; k < BANKS; k++) begin
            wr(3, 0, k, int'($urandom_range(0, 37)));
            wr(4, 0, k, int'($urandom_range(0, 35)) | (int'($urandom_range(0, 35)) << 6));
        end
        for (int k = 0; k < NSW; k++)
            wr(5, 0, k, int'($urandom_range(0, 35)) | (int'($urandom_range(0, 35)) << 6));
        wr(6, 0, 0, int'($urandom_range(0, 3)));
    endtask

    initial begin
        #(8ns * 200000);
        if (!ended) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int m = 0; m < NM; m++) begin
            m_nr[m] = 0; m_nc[m] = 0; m_amb[m] = 0;
            for (int k = 0; k < ROWS; k++)  m_row[m][k] = 0;
            for (int k = 0; k < SLOTS; k++) m_col[m][k] = 0;
        end
        for (int k = 0; k < BANKS; k++) begin m_bank[k] = 0; m_sz[k][0] = 0; m_sz[k][1] = 0; end
        for (int k = 0; k < NSW; k++) begin m_sw[k][0] = 0; m_sw[k][1] = 0; end
        m_szen = 0; m_csen = 0;

        repeat (3) @(negedge clk);
        check("R9 reset outputs", {out_valid, out_word}, '0);
        rst = 1'b0;
        @(negedge clk);
        req("R9 cleared tables", 36'h0_0000_0001, 0, 4'd5);
        idle("R1 R10 idle after request");

        // R3 / R8: basic row map, out-of-range index, far position
        wr(2, 0, 0, 1);
        wr(0, 0, 0, 3);
        wr(0, 0, 16, 7);
        req("R8 index 16 ignored, bit 7", 36'h80, 0, 4'd1);
        req("R3 row bit from position 3", 36'h8, 0, 4'd2);
        wr(0, 0, 0, 40);
        req("R8 position 40 reads zero", 36'hFFFFFFFFF, 0, 4'd3);

        // R4: interleave swap with priority
        wr(2, 0, 0, 2);
        wr(0, 0, 0, 12);
        wr(0, 0, 1, 20);
        wr(5, 0, 0, 12 | (20 << 6));
        wr(5, 0, 1, 12 | (5 << 6));
        wr(6, 0, 0, 2);
        req("R4 swap enabled", 36'h100000, 0, 4'd4);
        req("R4 pair priority", 36'h20, 0, 4'd4);
        wr(6, 0, 0, 0);
        req("R4 swap disabled", 36'h100000, 0, 4'd4);

        // R5 / R6: skipped slot and ambiguous mode
        for (int k = 0; k < SLOTS; k++) wr(1, 1, k, k);
        wr(2, 1, 0, 14 << 5);
        req("R5 slot 10 skipped", 36'h400, 1, 4'd6);
        req("R5 col bit 10 from slot 11", 36'h800, 1, 4'd6);
        req("R5 top column bit", 36'h4000, 1, 4'd6);
        wr(2, 1, 0, (14 << 5) | 512);
        req("R6 ambiguous drops top bit", 36'h4000, 1, 4'd6);
        req("R6 ambiguous keeps lower", 36'h2000, 1, 4'd6);

        // R7: bank swizzle
        wr(3, 0, 0, 2);
        wr(4, 0, 0, 3 | (4 << 6));
        wr(6, 0, 0, 1);
        req("R7 swizzle on", 36'h0C, 0, 4'd7);
        req("R7 swizzle on, one extra", 36'h14, 0, 4'd7);
        wr(6, 0, 0, 0);
        req("R7 swizzle off", 36'h0C, 0, 4'd7);

        // Random rounds, back-to-back requests
        for (int round = 0; round < 4; round++) begin
            rand_cfg();
            for (int n = 0; n < 60; n++) begin
                logic [35:0] a = {4'($urandom), $urandom};
                req("R2 R3 R4 R5 R6 R7 random", a, int'($urandom_range(0, 3)), 4'($urandom));
            end
            idle("R1 R10 idle after burst");
        end

        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule